// File: doc/BRIEF.md
# Hamming SEC-DED Codec for an 8-bit Memory Word

This block sits between a data source and a memory array that stores 13 bits per byte. On the write side it turns an 8-bit data byte into a 13-bit stored word. The word holds a 12-position Hamming code and one extra bit that keeps the total number of ones even. On the read side it takes the 13 bits fetched from the array and recomputes the check information as a syndrome. It then hands back the byte, corrected where that is possible, together with a 2-bit status code.

In the Hamming part, check bits occupy the power-of-two positions. Because of that, a nonzero syndrome is the number of the failing position. The overall parity bit is what tells a single error, which the block corrects, apart from two errors, which it can only report. Encoding and decoding are combinational. A parameter puts one register stage on all outputs, and that stage is on by default.

Top module: `hamming_guard`

## Requirements
- R1: Bit p of `wr_code` (p = 1..12) holds codeword position p. Data bits `wr_data[0]`..`wr_data[7]` sit at positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order. The check bit at position 2^j (j = 0..3) is bit j of the XOR of the position numbers of all data bits that are 1.
- R2: `wr_code[0]` is chosen so that the 13-bit `wr_code` always contains an even number of ones.
- R3: With `REG_OUT` = 1, every output reflects the inputs of the previous clock edge. A synchronous active-high `rst` drives `wr_code`, `rd_data` and `rd_status` to zero.
- R4: `rd_status` uses 0 = no error, 1 = corrected, 2 = check bit in error, 3 = uncorrectable. A fault-free `rd_code` gives status 0, and its data positions appear on `rd_data`.
- R5: One flipped data position gives status 1, and `rd_data` carries the original byte with that bit inverted back.
- R6: One flipped check position (1, 2, 4 or 8) gives status 2, and the data is passed through unaltered.
- R7: A flip of the overall parity bit alone (bit 0) gives status 1, and the data is unaltered.
- R8: Any two flipped bits give status 3. `rd_data` then shows the fetched data positions with no correction.
- R9: Odd overall parity with a syndrome above 12 gives status 3, and no bit is corrected.
- R10: Byte 0x39 encodes to 0x069F. If position 6 of that word is flipped, the syndrome is 6 and the decoder returns 0x39 with status 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 8 | Byte to be encoded |
| wr_code | output | 13 | Encoded word: bit 0 is overall parity, bits 1..12 are Hamming positions |
| rd_code | input | 13 | Word fetched from memory, same layout as `wr_code` |
| rd_data | output | 8 | Decoded and, where possible, corrected byte |
| rd_status | output | 2 | 0 no error, 1 corrected, 2 check-bit error, 3 uncorrectable |

## Verification
Four properties hold on every cycle, checked against the inputs of the previous edge:
- every produced word has even parity and carries the input byte in its data positions;
- any status other than "corrected" passes the fetched data through untouched;
- a correction changes at most one data bit;
- a fetched word with even parity only ever ends as "no error" or "uncorrectable".

Some behaviour only the bench scenarios can show. This covers the exact check-bit values, and which flipped position leads to which status. It also covers the case where three flips push the syndrome above the last position, and the one-cycle latency with the zeroed reset state.

// File: rtl/hg_pkg.sv
package hg_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_CHK   = 2'd2,
    ST_DBL   = 2'd3
  } hg_status_e;

  // smallest check width k with 2^k >= data + k + 1
  function automatic int chk_width(input int m);
    int k;
    k = 1;
    while ((1 << k) < m + k + 1) k = k + 1;
    return k;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // codeword position of data bit idx (0-based): the idx-th non-power-of-two >= 3
  function automatic int data_pos(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 3; p < 256; p++) begin
      if (!is_pow2(p) && res == 0) begin
        if (cnt == idx) res = p;
        cnt = cnt + 1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/hg_encode.sv
module hg_encode #(
  parameter int DATA_W = 8,
  localparam int CHK_W = hg_pkg::chk_width(DATA_W),
  localparam int POS_N = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [POS_N:0]    code_o
);

  logic [CHK_W-1:0] chk;

  always_comb begin
    code_o = '0;
    chk    = '0;
    for (int i = 0; i < DATA_W; i++) begin
      code_o[hg_pkg::data_pos(i)] = data_i[i];
      if (data_i[i]) chk = chk ^ CHK_W'(hg_pkg::data_pos(i));
    end
    for (int j = 0; j < CHK_W; j++) code_o[1 << j] = chk[j];
    code_o[0] = ^code_o[POS_N:1];
  end

endmodule

// File: rtl/hg_syndrome.sv
module hg_syndrome #(
  parameter int DATA_W = 8,
  localparam int CHK_W = hg_pkg::chk_width(DATA_W),
  localparam int POS_N = DATA_W + CHK_W
) (
  input  logic [POS_N:0]   code_i,
  output logic [CHK_W-1:0] syn_o,
  output logic             odd_o
);

  // XOR of the numbers of all set positions = stored check ^ recomputed check
  always_comb begin
    syn_o = '0;
    for (int p = 1; p <= POS_N; p++) begin
      if (code_i[p]) syn_o = syn_o ^ CHK_W'(p);
    end
  end

  assign odd_o = ^code_i;

endmodule

// File: rtl/hg_correct.sv
module hg_correct
  import hg_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHK_W = hg_pkg::chk_width(DATA_W),
  localparam int POS_N = DATA_W + CHK_W
) (
  input  logic [POS_N:0]    code_i,
  input  logic [CHK_W-1:0]  syn_i,
  input  logic              odd_i,
  output logic [DATA_W-1:0] data_o,
  output hg_status_e        status_o
);

  logic [POS_N:0] fixed;

  always_comb begin
    fixed    = code_i;
    status_o = ST_CLEAN;
    if (syn_i == '0) begin
      status_o = odd_i ? ST_FIXED : ST_CLEAN;
    end else if (!odd_i) begin
      status_o = ST_DBL;
    end else if ($countones(syn_i) == 1) begin
      status_o = ST_CHK;
    end else if (int'(syn_i) > POS_N) begin
      status_o = ST_DBL;
    end else begin
      status_o = ST_FIXED;
      for (int p = 1; p <= POS_N; p++) begin
        if (CHK_W'(p) == syn_i) fixed[p] = ~code_i[p];
      end
    end
    for (int i = 0; i < DATA_W; i++) data_o[i] = fixed[hg_pkg::data_pos(i)];
  end

endmodule

// File: rtl/hamming_guard.sv
module hamming_guard
  import hg_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int CHK_W  = hg_pkg::chk_width(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] wr_code,
  input  logic [CODE_W-1:0] rd_code,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_status
);

  logic [CODE_W-1:0] enc_code;
  logic [CHK_W-1:0]  syn;
  logic              odd;
  logic [DATA_W-1:0] dec_data;
  hg_status_e        dec_status;

  hg_encode #(.DATA_W(DATA_W)) i_enc (
    .data_i (wr_data),
    .code_o (enc_code)
  );

  hg_syndrome #(.DATA_W(DATA_W)) i_syn (
    .code_i (rd_code),
    .syn_o  (syn),
    .odd_o  (odd)
  );

  hg_correct #(.DATA_W(DATA_W)) i_fix (
    .code_i   (rd_code),
    .syn_i    (syn),
    .odd_i    (odd),
    .data_o   (dec_data),
    .status_o (dec_status)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          wr_code   <= '0;
          rd_data   <= '0;
          rd_status <= 2'd0;
        end else begin
          wr_code   <= enc_code;
          rd_data   <= dec_data;
          rd_status <= dec_status;
        end
      end
    end else begin : g_comb
      assign wr_code   = enc_code;
      assign rd_data   = dec_data;
      assign rd_status = dec_status;
    end
  endgenerate

endmodule

// File: rtl/hamming_guard_chk.sv
module hamming_guard_chk #(
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int CHK_W  = hg_pkg::chk_width(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] wr_data,
  input logic [CODE_W-1:0] wr_code,
  input logic [CODE_W-1:0] rd_code,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        rd_status
);

  logic [DATA_W-1:0] q_wdata;
  logic [CODE_W-1:0] q_code;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk) begin
        if (rst) begin
          q_wdata <= '0;
          q_code  <= '0;
        end else begin
          q_wdata <= wr_data;
          q_code  <= rd_code;
        end
      end
    end else begin : g_now
      assign q_wdata = wr_data;
      assign q_code  = rd_code;
    end
  endgenerate

  function automatic logic [DATA_W-1:0] pull(input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = c[hg_pkg::data_pos(i)];
    return r;
  endfunction

  // R2
  wr_even_chk: assert property (@(posedge clk) disable iff (rst)
    (^wr_code) == 1'b0);

  // R1
  wr_data_place_chk: assert property (@(posedge clk) disable iff (rst)
    pull(wr_code) == q_wdata);

  // R6
  nofix_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_status != 2'd1) |-> (rd_data == pull(q_code)));

  // R5
  one_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_status == 2'd1) |-> ($countones(rd_data ^ pull(q_code)) <= 1));

  // R8
  even_class_chk: assert property (@(posedge clk) disable iff (rst)
    ((^q_code) == 1'b0) |-> (rd_status == 2'd0 || rd_status == 2'd3));

  // R4
  clean_even_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_status == 2'd0) |-> ((^q_code) == 1'b0));

endmodule

bind hamming_guard hamming_guard_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_data   (wr_data),
  .wr_code   (wr_code),
  .rd_code   (rd_code),
  .rd_data   (rd_data),
  .rd_status (rd_status)
);

// File: tb/test_hamming_guard.sv
module test_hamming_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  wr_data = '0;
  logic [12:0] wr_code;
  logic [12:0] rd_code = '0;
  logic [7:0]  rd_data;
  logic [1:0]  rd_status;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hamming_guard i_hamming_guard (
    .clk       (clk),
    .rst       (rst),
    .wr_data   (wr_data),
    .wr_code   (wr_code),
    .rd_code   (rd_code),
    .rd_data   (rd_data),
    .rd_status (rd_status)
  );

  // {byte, expected 13-bit word}
  localparam int NV = 5;
  localparam logic [20:0] VEC [NV] = '{
    {8'h00, 13'h0000},
    {8'h39, 13'h069F},
    {8'hFF, 13'h1EEE},
    {8'h01, 13'h000F},
    {8'h80, 13'h1111}
  };

  localparam int DPOS [8] = '{3, 5, 6, 7, 9, 10, 11, 12};

  function automatic logic [7:0] raw(input logic [12:0] c);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = c[DPOS[i]];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic read_case(input logic [12:0] c, input logic [7:0] ed, input logic [1:0] es, input string tag);
    @(negedge clk);
    rd_code = c;
    @(negedge clk);
    check(rd_data == ed, tag, rd_data, ed);
    check(rd_status == es, tag, rd_status, es);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R3: reset state while inputs are nonzero
    wr_data = 8'hFF;
    rd_code = 13'h1EEE ^ 13'h0040;
    repeat (3) @(negedge clk);
    check(wr_code == 13'h0, "R3", wr_code, 0);
    check(rd_data == 8'h0, "R3", rd_data, 0);
    check(rd_status == 2'd0, "R3", rd_status, 0);
    rst = 1'b0;

    // R3: one-cycle latency
    @(negedge clk);
    wr_data = 8'h39;
    #1;
    check(wr_code == 13'h1EEE, "R3", wr_code, 13'h1EEE);
    @(negedge clk);
    check(wr_code == 13'h069F, "R3", wr_code, 13'h069F);

    // R1 R2 R4: table walk, encode and clean read-back
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_data = VEC[v][20:13];
      rd_code = VEC[v][12:0];
      @(negedge clk);
      check(wr_code == VEC[v][12:0], "R1", wr_code, VEC[v][12:0]);
      check((^wr_code) == 1'b0, "R2", wr_code, 0);
      check(rd_data == VEC[v][20:13], "R4", rd_data, VEC[v][20:13]);
      check(rd_status == 2'd0, "R4", rd_status, 0);
    end

    // R10: worked example
    read_case(13'h069F ^ 13'h0040, 8'h39, 2'd1, "R10");

    // R5 R6 R7: every single flip
    for (int v = 0; v < NV; v++) begin
      for (int p = 0; p < 13; p++) begin
        if (p == 0)
          read_case(VEC[v][12:0] ^ 13'h1, VEC[v][20:13], 2'd1, "R7");
        else if (p == 1 || p == 2 || p == 4 || p == 8)
          read_case(VEC[v][12:0] ^ (13'h1 << p), VEC[v][20:13], 2'd2, "R6");
        else
          read_case(VEC[v][12:0] ^ (13'h1 << p), VEC[v][20:13], 2'd1, "R5");
      end
    end

    // R8: every double flip
    for (int v = 0; v < NV; v++) begin
      for (int p = 0; p < 13; p++) begin
        for (int q = p + 1; q < 13; q++) begin
          logic [12:0] c2;
          c2 = VEC[v][12:0] ^ (13'h1 << p) ^ (13'h1 << q);
          read_case(c2, raw(c2), 2'd3, "R8");
        end
      end
    end

    // R9: odd parity, syndrome beyond position 12
    begin
      logic [12:0] c3;
      c3 = 13'h069F ^ (13'h1 << 3) ^ (13'h1 << 5) ^ (13'h1 << 9);   // syndrome 15
      read_case(c3, raw(c3), 2'd3, "R9");
      c3 = 13'h1EEE ^ (13'h1 << 1) ^ (13'h1 << 4) ^ (13'h1 << 8);   // syndrome 13
      read_case(c3, raw(c3), 2'd3, "R9");
      c3 = 13'h1111 ^ (13'h1 << 6) ^ (13'h1 << 8) ^ 13'h1;          // syndrome 14
      read_case(c3, raw(c3), 2'd3, "R9");
    end

    finish_run();
  end

endmodule